// File: doc/BRIEF.md
# Two-Wire Slave Front End for an Eight-Channel Sampling Converter

This block is the serial-bus slave logic for a 12-bit, eight-input sampling converter. It runs on a system clock and oversamples the two bus wires. Each wire passes through a two-stage synchroniser and a glitch filter. The block then recognises Start, repeated Start and Stop. It answers a 7-bit address made of a fixed five-bit prefix and two board strap pins. It drives the bus only through two pull-low enables, one for SDA and one for SCL.

A write transfer carries one or more command bytes. The upper nibble of a command names the input pair, and bits 3:2 carry the power setting. A conversion request goes to the core while the command is still arriving. A read transfer returns the most recent result as two bytes. The block tracks the high-speed bus mode. In that mode a read address that arrives before the result is ready is held off by keeping SCL low until the core reports that it has finished.

Top module: `adcif_front`

## Requirements
- R1: After reset neither pull-low enable is active, high-speed mode is off and no conversion request is raised.
- R2: A pulse on a bus wire that lasts fewer than FILT_LEN system clocks is ignored, so a short SDA dip while SCL is high creates no Start.
- R3: An address byte whose bits 7:3 equal 10010 and whose bits 2:1 equal the latched straps is acknowledged: SDA is held low through the ninth clock. Bit 0 selects the direction, 1 for read and 0 for write.
- R4: The strap inputs are captured only while reset is asserted. A later change on the straps does not change the address the block answers to.
- R5: After an address byte that does not match, the block never pulls SDA low until the next Start or Stop. A following byte clocked by the master reads as all ones.
- R6: Each command byte in a write transfer is acknowledged. A single-cycle conversion request is raised once the fourth command bit (bit 4) is sampled. The input select output then holds command bits 7:4, and the power output holds bits 3:2 from the end of the byte.
- R7: A read returns two bytes, MSB first. The first byte is four zeros followed by result bits 11:8, and the second byte is result bits 7:0.
- R8: A read before any conversion has completed returns 0x00 and 0x00.
- R9: When the master answers a slave-sent byte with NACK, the block releases SDA and stays silent until the next Start or Stop.
- R10: A byte of the form 00001xxx received in standard/fast mode gets no acknowledge and turns high-speed mode on.
- R11: In high-speed mode, if a conversion is still in progress when a matching read address completes, SCL is held low until the core signals done. The returned bytes then carry that new result. In standard/fast mode SCL is never held.
- R12: A Stop returns the block to standard/fast mode, and a repeated Start leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| scl_in | input | 1 | Sensed level of the SCL wire |
| sda_in | input | 1 | Sensed level of the SDA wire |
| strap_in | input | 2 | Board strap levels forming address bits 2:1 |
| conv_done | input | 1 | Single-cycle pulse from the core when a result is ready |
| conv_data | input | RES_W | Result from the core, valid with conv_done |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_hold | output | 1 | 1 pulls SCL low (clock stretching) |
| conv_start | output | 1 | Single-cycle conversion request to the core |
| conv_sel | output | 4 | Input-pair select: single/differential flag and three channel bits |
| conv_pd | output | 2 | Power setting taken from the command byte |
| hs_mode | output | 1 | High-speed bus mode active |

## Verification
The bench builds the block with FILT_LEN = 4, RES_W = 12 and the default prefix. The bus half-period is 20 system clocks, which leaves room for the synchroniser and filter delay. The bench also injects a two-clock SDA glitch, which lies inside the filter window and so tests its rejection. A behavioural core stub has a programmable latency. It is set short for standard/fast reads and long for the high-speed read, so the SCL hold becomes visible and its release can be tied to the returned data.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

  localparam logic [4:0] ADDR_PREFIX_DEF = 5'b10010;
  localparam logic [4:0] MCODE_PREFIX    = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACKA,
    ST_CMD,
    ST_ACKC,
    ST_TX,
    ST_TXA,
    ST_IGN
  } eng_state_e;

endpackage

// File: rtl/adcif_line_filter.sv
module adcif_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 != dout) begin
        if (cnt == LAST) begin
          dout <= s2;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/adcif_cond_detect.sv
module adcif_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_comb begin
    scl_rise = scl & ~scl_q;
    scl_fall = ~scl & scl_q;
    start_ev = scl & scl_q & sda_q & ~sda;
    stop_ev  = scl & scl_q & ~sda_q & sda;
  end

endmodule

// File: rtl/adcif_engine.sv
module adcif_engine
  import adcif_pkg::*;
#(
  parameter int         RES_W  = 12,
  parameter logic [4:0] PREFIX = ADDR_PREFIX_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_f,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic [1:0]       strap,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             sda_oe,
  output logic             scl_hold,
  output logic             conv_start,
  output logic [3:0]       conv_sel,
  output logic [1:0]       conv_pd,
  output logic             hs_mode
);
  localparam int HI_W   = RES_W - 8;
  localparam int LO_PAD = 8 - HI_W;

  eng_state_e       state;
  logic [7:0]       sh;
  logic [3:0]       cnt;
  logic             rw, ack_in, byte_sel, pending;
  logic [RES_W-1:0] res;
  logic [7:0]       tx;
  logic [7:0]       hi_byte, lo_byte, next_tx;
  logic             addr_hit, mcode;

  always_comb begin
    hi_byte  = {{LO_PAD{1'b0}}, res[RES_W-1:8]};
    lo_byte  = res[7:0];
    next_tx  = byte_sel ? hi_byte : lo_byte;
    addr_hit = (sh[7:3] == PREFIX) && (sh[2:1] == strap);
    mcode    = (sh[7:3] == MCODE_PREFIX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sh         <= '0;
      cnt        <= '0;
      rw         <= 1'b0;
      ack_in     <= 1'b0;
      byte_sel   <= 1'b0;
      pending    <= 1'b0;
      res        <= '0;
      tx         <= '0;
      sda_oe     <= 1'b0;
      scl_hold   <= 1'b0;
      conv_start <= 1'b0;
      conv_sel   <= '0;
      conv_pd    <= '0;
      hs_mode    <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (conv_done) begin
        res     <= conv_data;
        pending <= 1'b0;
      end
      if (scl_hold && !pending) scl_hold <= 1'b0;

      if (start_ev) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        scl_hold <= 1'b0;
      end else if (stop_ev) begin
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        scl_hold <= 1'b0;
        hs_mode  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (!hs_mode && mcode) begin
                hs_mode <= 1'b1;
                state   <= ST_IGN;
              end else if (addr_hit) begin
                rw     <= sh[0];
                sda_oe <= 1'b1;
                state  <= ST_ACKA;
                if (sh[0] && hs_mode && pending) scl_hold <= 1'b1;
              end else begin
                state <= ST_IGN;
              end
            end
          end
          ST_ACKA: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                state    <= ST_TX;
                tx       <= hi_byte;
                sda_oe   <= ~hi_byte[7];
                byte_sel <= 1'b0;
              end else begin
                state  <= ST_CMD;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_CMD: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
              if (cnt == 4'd3) begin
                conv_start <= 1'b1;
                pending    <= 1'b1;
                conv_sel   <= {sh[2:0], sda_f};
              end
            end else if (scl_fall && cnt == 4'd8) begin
              conv_pd <= sh[3:2];
              sda_oe  <= 1'b1;
              state   <= ST_ACKC;
            end
          end
          ST_ACKC: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_CMD;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_TXA;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_TXA: begin
            if (scl_rise) begin
              ack_in <= ~sda_f;
            end else if (scl_fall) begin
              cnt <= '0;
              if (ack_in) begin
                state    <= ST_TX;
                byte_sel <= ~byte_sel;
                tx       <= next_tx;
                sda_oe   <= ~next_tx[7];
              end else begin
                state <= ST_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_silent_when_ignoring_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGN) |-> !sda_oe)
    else $error("SDA driven while ignoring traffic");

  assert_request_single_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start)
    else $error("conversion request longer than one cycle");

  assert_hold_only_in_hs_R11: assert property (@(posedge clk) disable iff (rst)
    scl_hold |-> hs_mode)
    else $error("SCL held outside high-speed mode");

  assert_hs_exit_on_stop_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(hs_mode) |-> $past(stop_ev))
    else $error("high-speed mode left without a Stop");

endmodule

// File: rtl/adcif_front.sv
module adcif_front
  import adcif_pkg::*;
#(
  parameter int         FILT_LEN = 3,
  parameter int         RES_W    = 12,
  parameter logic [4:0] PREFIX   = ADDR_PREFIX_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [1:0]       strap_in,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             sda_oe,
  output logic             scl_hold,
  output logic             conv_start,
  output logic [3:0]       conv_sel,
  output logic [1:0]       conv_pd,
  output logic             hs_mode
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic [1:0]        strap_q;

  assign raw = {scl_in, sda_in};

  generate
    for (genvar i = 0; i < NLINES; i++) begin : g_line
      adcif_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .din  (raw[i]),
        .dout (filt[i])
      );
    end
  endgenerate

  adcif_cond_detect u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl      (filt[1]),
    .sda      (filt[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_in;
  end

  assert_strap_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(strap_q))
    else $error("strap latch changed outside reset");

  adcif_engine #(.RES_W(RES_W), .PREFIX(PREFIX)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_f      (filt[0]),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .strap      (strap_q),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .sda_oe     (sda_oe),
    .scl_hold   (scl_hold),
    .conv_start (conv_start),
    .conv_sel   (conv_sel),
    .conv_pd    (conv_pd),
    .hs_mode    (hs_mode)
  );

endmodule

// File: tb/adcif_front_test.sv
module adcif_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 20;
  localparam int NV         = 5;
  localparam logic [19:0] VECS [NV] = '{
    20'h84ABC, 20'hF0FFF, 20'h0C000, 20'h5A801, 20'hB417E
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0]  strap_in = 2'b10;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        sda_oe, scl_hold, conv_start, hs_mode;
  logic [3:0]  conv_sel;
  logic [1:0]  conv_pd;

  int nvec = 0, nbad = 0, nstart = 0, stretch_cnt = 0, conv_lat = 100;
  logic [11:0] stub_val = '0;
  logic        busy = 1'b0;
  int          lat_cnt = 0;

  wire scl_line = m_scl & ~scl_hold;
  wire sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcif_front #(.FILT_LEN(4), .RES_W(12)) uut (
    .clk(clk), .rst(rst), .scl_in(scl_line), .sda_in(sda_line),
    .strap_in(strap_in), .conv_done(conv_done), .conv_data(conv_data),
    .sda_oe(sda_oe), .scl_hold(scl_hold), .conv_start(conv_start),
    .conv_sel(conv_sel), .conv_pd(conv_pd), .hs_mode(hs_mode)
  );

  // behavioural converter core
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (rst) busy <= 1'b0;
    else if (conv_start) begin
      busy    <= 1'b1;
      lat_cnt <= conv_lat;
      nstart  <= nstart + 1;
    end else if (busy) begin
      if (lat_cnt == 0) begin
        busy      <= 1'b0;
        conv_done <= 1'b1;
        conv_data <= stub_val;
      end else lat_cnt <= lat_cnt - 1;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wait_clk(H);
    m_scl = 1'b1; wait_clk(H);
    m_sda = 1'b0; wait_clk(H);
    m_scl = 1'b0; wait_clk(H);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wait_clk(H);
    m_scl = 1'b1; wait_clk(H);
    m_sda = 1'b1; wait_clk(H);
  endtask

  task automatic write_bit(input logic b, input logic glitch);
    m_sda = b; wait_clk(H);
    m_scl = 1'b1; @(negedge clk);
    while (!scl_line) begin stretch_cnt++; @(negedge clk); end
    if (glitch) begin
      wait_clk(6); m_sda = ~b; wait_clk(2); m_sda = b; wait_clk(H - 8);
    end else wait_clk(H);
    m_scl = 1'b0;
  endtask

  task automatic read_bit(output logic b);
    m_sda = 1'b1; wait_clk(H);
    m_scl = 1'b1; @(negedge clk);
    while (!scl_line) begin stretch_cnt++; @(negedge clk); end
    wait_clk(H/2); b = sda_line; wait_clk(H/2);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input logic glitch, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) write_bit(v[i], glitch && (i == 7));
    read_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin read_bit(b); v[i] = b; end
    write_bit(~give_ack, 1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin : main
    logic       ack;
    logic [7:0] b0, b1;
    int         n0;
    wait_clk(5);
    rst = 1'b0;
    strap_in = 2'b01;   // R4: change after reset must not matter
    wait_clk(3);

    // R1 reset state
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_hold", scl_hold, 0);
    chk("R1 hs_mode", hs_mode, 0);
    chk("R1 conv_start", conv_start, 0);

    // R8 read before any conversion
    bus_start; send_byte(8'h95, 1'b0, ack);
    chk("R3 read addr ack", ack, 1);
    recv_byte(1'b1, b0); recv_byte(1'b0, b1);
    chk("R8 first byte", b0, 8'h00);
    chk("R8 second byte", b1, 8'h00);
    bus_stop;

    // R4 new strap value is not answered
    bus_start; send_byte(8'h93, 1'b0, ack);
    chk("R4 strap change ignored", ack, 0);
    bus_stop;

    // R5 non-matching address: silent
    bus_start; send_byte(8'h91, 1'b0, ack);
    chk("R5 no ack", ack, 0);
    recv_byte(1'b1, b0);
    chk("R5 silent byte", b0, 8'hFF);
    chk("R5 sda released", sda_oe, 0);
    bus_stop;

    // R2 glitch inside filter window
    bus_start; send_byte(8'h94, 1'b1, ack);
    chk("R2 glitch rejected, ack", ack, 1);
    bus_stop;

    // table: write command, read result in standard/fast mode
    for (int k = 0; k < NV; k++) begin
      logic [7:0]  cmd;
      logic [11:0] val;
      cmd = VECS[k][19:12];
      val = VECS[k][11:0];
      stub_val = val; conv_lat = 100; n0 = nstart;
      bus_start; send_byte(8'h94, 1'b0, ack);
      chk("R3 write addr ack", ack, 1);
      send_byte(cmd, 1'b0, ack);
      chk("R6 command ack", ack, 1);
      chk("R6 one request", nstart, n0 + 1);
      chk("R6 select", conv_sel, cmd[7:4]);
      chk("R6 power", conv_pd, cmd[3:2]);
      stretch_cnt = 0;
      bus_start; send_byte(8'h95, 1'b0, ack);
      chk("R3 read addr ack", ack, 1);
      recv_byte(1'b1, b0); recv_byte(1'b0, b1);
      chk("R7 high byte", b0, {4'b0000, val[11:8]});
      chk("R7 low byte", b1, val[7:0]);
      chk("R11 no stretch in F/S", stretch_cnt, 0);
      wait_clk(4);
      chk("R9 released after NACK", sda_line, 1);
      bus_stop;
    end

    // high-speed sequence
    stub_val = 12'h3C5; conv_lat = 1500;
    bus_start; send_byte(8'h09, 1'b0, ack);
    chk("R10 master code not acked", ack, 0);
    chk("R10 hs on", hs_mode, 1);
    bus_start; send_byte(8'h94, 1'b0, ack);
    chk("R3 hs write ack", ack, 1);
    send_byte(8'hC4, 1'b0, ack);
    chk("R6 hs command ack", ack, 1);
    bus_start;
    chk("R12 hs kept over repeated Start", hs_mode, 1);
    stretch_cnt = 0;
    send_byte(8'h95, 1'b0, ack);
    chk("R11 read ack after hold", ack, 1);
    chk("R11 stretch seen", stretch_cnt > 0, 1);
    recv_byte(1'b1, b0); recv_byte(1'b0, b1);
    chk("R11 high byte", b0, 8'h03);
    chk("R11 low byte", b1, 8'hC5);
    bus_stop;
    wait_clk(10);
    chk("R12 stop leaves hs", hs_mode, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule